// File: doc/BRIEF.md
# Stack Return Sequencer

This block is the multi-cycle controller that unwinds the stack for an 8-bit processor with a 16-bit stack pointer. It handles three inherent operations: a stack-pointer reset that sets only the low byte, a return from subroutine, and a return from interrupt. A decoded opcode arrives with a one-cycle start strobe. The block then walks its own step counter. For every byte pulled it drives a byte-wide read port addressed just above the stack pointer, and it writes the pulled byte into the condition codes, the accumulator, the index low byte or one of the program counter bytes.

Each pull takes one cycle. The read goes to SP+1, and the stack pointer moves to that address at the end of the cycle, which gives pre-increment pull behaviour. Both return operations end with fixed refill cycles, so the interrupt return lasts 9 cycles and the subroutine return lasts 5. Completion is shown by a one-cycle done pulse in the last cycle. The register values that result are visible on the outputs for the surrounding core.

Top module: `stack_unwind_seq`

## Requirements
- R1: Opcode 0x9C with start sets sp_o[7:0] to 0xFF and leaves sp_o[15:8] unchanged. It completes in the start cycle itself, with done_o high in that cycle and no memory read.
- R2: Each pull drives mem_rd_o high with mem_addr_o equal to sp_o+1 and takes mem_rdata_i in the same cycle. After that edge, sp_o equals the address that was read. mem_rd_o is never high outside a pull cycle.
- R3: Opcode 0x81 pulls two bytes. The first goes to pc_o[15:8] and the second to pc_o[7:0].
- R4: Opcode 0x80 pulls five bytes into, in this order: ccr_o, acc_o, idx_o[7:0], pc_o[15:8], pc_o[7:0].
- R5: Counting the start cycle as cycle 1, done_o is high in cycle 9 for 0x80 and in cycle 5 for 0x81. It is high for exactly one cycle per accepted operation.
- R6: ccr_o changes only during an 0x80 sequence. Opcodes 0x81 and 0x9C leave it unchanged.
- R7: idx_o[15:8] is never written and keeps its reset value.
- R8: While busy_o is high, start_i is ignored whatever the opcode.
- R9: The stack pointer wraps from 0xFFFF to 0x0000 when it increments.
- R10: A start with any other opcode is ignored: no done_o, no busy_o, no read, and sp_o is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe for opcode_i |
| opcode_i | input | 8 | Decoded opcode |
| mem_rd_o | output | 1 | Stack read strobe |
| mem_addr_o | output | 16 | Stack read address |
| mem_rdata_i | input | 8 | Read data, same cycle |
| sp_o | output | 16 | Stack pointer |
| ccr_o | output | 8 | Condition code register |
| acc_o | output | 8 | Accumulator |
| idx_o | output | 16 | Index register, high:low |
| pc_o | output | 16 | Program counter |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Completion pulse |

## Verification
The bench starts the stack pointer at 0xFFFC, so the first interrupt return reads across the 0xFFFF to 0x0000 boundary. A design that carries into a seventeenth bit or fails to wrap would read the wrong addresses and would leave sp_o wrong afterwards. Each test logs the order of read addresses and pulled bytes and checks that the stack-pointer reset leaves the high byte at 0xFF and not 0x00. A design that post-increments, swaps the program counter bytes or clears the high byte would load the wrong values. A stack-pointer reset strobe injected in the middle of each return must leave sp_o at the pulled count and produce one done pulse, not an early or doubled one. A stray opcode must produce no done pulse.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 16;
  localparam int RTI_CYCLES  = 9;
  localparam int RTS_CYCLES  = 5;

  localparam logic [DATA_W-1:0] OPC_RSP = 8'h9C;
  localparam logic [DATA_W-1:0] OPC_RTI = 8'h80;
  localparam logic [DATA_W-1:0] OPC_RTS = 8'h81;

  typedef enum logic [1:0] {OP_NONE, OP_RSP, OP_RTS, OP_RTI} op_e;
  typedef enum logic [2:0] {TGT_NONE, TGT_CCR, TGT_ACC, TGT_IXL, TGT_PCH, TGT_PCL} tgt_e;
endpackage

// File: rtl/stk_plan.sv
module stk_plan
  import stk_pkg::*;
#(
  parameter int STEP_W = 4
) (
  input  op_e               op_i,
  input  logic [STEP_W-1:0] step_i,
  output tgt_e              tgt_o,
  output logic              last_o
);
  localparam logic [STEP_W-1:0] RTI_LAST = STEP_W'(RTI_CYCLES - 1);
  localparam logic [STEP_W-1:0] RTS_LAST = STEP_W'(RTS_CYCLES - 1);

  // step 0 is the accept cycle; pulls follow, then refill cycles
  always_comb begin
    tgt_o  = TGT_NONE;
    last_o = 1'b0;
    unique case (op_i)
      OP_RTI: begin
        case (step_i)
          STEP_W'(1): tgt_o = TGT_CCR;
          STEP_W'(2): tgt_o = TGT_ACC;
          STEP_W'(3): tgt_o = TGT_IXL;
          STEP_W'(4): tgt_o = TGT_PCH;
          STEP_W'(5): tgt_o = TGT_PCL;
          default:    tgt_o = TGT_NONE;
        endcase
        last_o = (step_i == RTI_LAST);
      end
      OP_RTS: begin
        case (step_i)
          STEP_W'(1): tgt_o = TGT_PCH;
          STEP_W'(2): tgt_o = TGT_PCL;
          default:    tgt_o = TGT_NONE;
        endcase
        last_o = (step_i == RTS_LAST);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr
  import stk_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_SP = 16'h00FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rsp_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] sp_inc_o
);
  logic [ADDR_W-1:0] sp_q;

  assign sp_inc_o = sp_q + ADDR_W'(1);  // modulo 2^16
  assign sp_o     = sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sp_q <= RESET_SP;
    else if (rsp_i)    sp_q[7:0] <= 8'hFF;
    else if (inc_i)    sp_q <= sp_inc_o;
  end

  AST_RSP_LOW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_i |=> (sp_q[7:0] == 8'hFF) && (sp_q[15:8] == $past(sp_q[15:8]))); // R1
  AST_SP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !rsp_i && sp_q == '1) |=> sp_q == '0); // R9
endmodule

// File: rtl/stk_regs.sv
module stk_regs
  import stk_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_CCR = 8'h00,
  parameter logic [ADDR_W-1:0] RESET_HX  = 16'h0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  tgt_e              tgt_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] ccr_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [ADDR_W-1:0] idx_o,
  output logic [ADDR_W-1:0] pc_o
);
  logic [DATA_W-1:0] ccr_q, acc_q, ixl_q, pch_q, pcl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ccr_q <= RESET_CCR;
      acc_q <= '0;
      ixl_q <= RESET_HX[7:0];
      pch_q <= '0;
      pcl_q <= '0;
    end else if (wr_i) begin
      case (tgt_i)
        TGT_CCR: ccr_q <= data_i;
        TGT_ACC: acc_q <= data_i;
        TGT_IXL: ixl_q <= data_i;
        TGT_PCH: pch_q <= data_i;
        TGT_PCL: pcl_q <= data_i;
        default: ;
      endcase
    end
  end

  assign ccr_o = ccr_q;
  assign acc_o = acc_q;
  assign idx_o = {RESET_HX[15:8], ixl_q};  // high byte never pulled
  assign pc_o  = {pch_q, pcl_q};

  AST_IDX_HIGH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(idx_o[15:8])); // R7
endmodule

// File: rtl/stack_unwind_seq.sv
module stack_unwind_seq
  import stk_pkg::*;
#(
  parameter int                STEP_W    = 4,
  parameter logic [ADDR_W-1:0] RESET_SP  = 16'h00FF,
  parameter logic [ADDR_W-1:0] RESET_HX  = 16'h0000,
  parameter logic [DATA_W-1:0] RESET_CCR = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] opcode_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic [DATA_W-1:0] ccr_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [ADDR_W-1:0] idx_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              busy_o,
  output logic              done_o
);
  op_e               dec_op, op_q;
  logic              busy_q, accept, last, pull, rsp_now;
  logic [STEP_W-1:0] step_q;
  tgt_e              tgt;
  logic [ADDR_W-1:0] sp_inc;

  always_comb begin
    unique case (opcode_i)
      OPC_RSP: dec_op = OP_RSP;
      OPC_RTS: dec_op = OP_RTS;
      OPC_RTI: dec_op = OP_RTI;
      default: dec_op = OP_NONE;
    endcase
  end

  assign accept  = start_i && !busy_q;
  assign rsp_now = accept && (dec_op == OP_RSP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= OP_NONE;
      step_q <= '0;
    end else if (busy_q) begin
      if (last) begin
        busy_q <= 1'b0;
        op_q   <= OP_NONE;
        step_q <= '0;
      end else begin
        step_q <= step_q + STEP_W'(1);
      end
    end else if (accept && (dec_op == OP_RTS || dec_op == OP_RTI)) begin
      busy_q <= 1'b1;
      op_q   <= dec_op;
      step_q <= STEP_W'(1);
    end
  end

  stk_plan #(.STEP_W(STEP_W)) u_plan (
    .op_i   (op_q),
    .step_i (step_q),
    .tgt_o  (tgt),
    .last_o (last)
  );

  assign pull = busy_q && (tgt != TGT_NONE);

  stk_ptr #(.RESET_SP(RESET_SP)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rsp_i    (rsp_now),
    .inc_i    (pull),
    .sp_o     (sp_o),
    .sp_inc_o (sp_inc)
  );

  stk_regs #(.RESET_CCR(RESET_CCR), .RESET_HX(RESET_HX)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (pull),
    .tgt_i  (tgt),
    .data_i (mem_rdata_i),
    .ccr_o  (ccr_o),
    .acc_o  (acc_o),
    .idx_o  (idx_o),
    .pc_o   (pc_o)
  );

  assign mem_rd_o   = pull;
  assign mem_addr_o = sp_inc;
  assign busy_o     = busy_q;
  assign done_o     = (busy_q && last) || rsp_now;

  AST_PULL_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> sp_o == $past(mem_addr_o)); // R2
  AST_NO_IDLE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_rd_o); // R2
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && done_o) |=> !busy_o); // R5
  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o && $stable(op_q)); // R8
  AST_CCR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o || op_q != OP_RTI) |=> $stable(ccr_o)); // R6
  AST_BAD_OP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && dec_op == OP_NONE) |=> !busy_o && $stable(sp_o)); // R10
endmodule

// File: tb/stack_unwind_seq_bench.sv
`timescale 1ns/1ps
module stack_unwind_seq_bench;
  localparam logic [15:0] SP0  = 16'hFFFC;
  localparam logic [15:0] HX0  = 16'h5A3C;
  localparam logic [7:0]  CCR0 = 8'h60;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  opcode_i = 8'h00;
  logic        mem_rd_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_rdata_i;
  logic [15:0] sp_o, idx_o, pc_o;
  logic [7:0]  ccr_o, acc_o;
  logic        busy_o, done_o;

  logic [7:0]  salt = 8'h00;
  int          checks = 0, fails = 0;
  int          rd_n = 0;
  logic [15:0] rd_addr [8];
  logic [15:0] m_sp;
  logic [15:0] m_pc;
  logic [7:0]  m_ccr, m_acc, m_ixl;

  always #10 clk_i = ~clk_i;  // 50 MHz

  function automatic logic [7:0] mem_f(input logic [15:0] a, input logic [7:0] s);
    return a[7:0] ^ a[15:8] ^ s;
  endfunction

  assign mem_rdata_i = mem_f(mem_addr_o, salt);

  always @(posedge clk_i) begin
    if (mem_rd_o) begin
      if (rd_n < 8) rd_addr[rd_n] = mem_addr_o;
      rd_n = rd_n + 1;
    end
  end

  stack_unwind_seq #(.RESET_SP(SP0), .RESET_HX(HX0), .RESET_CCR(CCR0)) u_stack_unwind_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .opcode_i(opcode_i),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
    .sp_o(sp_o), .ccr_o(ccr_o), .acc_o(acc_o), .idx_o(idx_o), .pc_o(pc_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // Drives one start; cycle 1 is the start cycle. Optional stray RSP in cycle 3.
  task automatic run_op(input logic [7:0] op, input bit inject, output int done_at, output int done_cnt);
    done_at = 0; done_cnt = 0; rd_n = 0;
    @(negedge clk_i);
    start_i = 1'b1; opcode_i = op;
    for (int c = 1; c <= 14; c++) begin
      #5;
      if (done_o) begin
        done_cnt++;
        if (done_at == 0) done_at = c;
      end
      @(negedge clk_i);
      start_i  = inject && (c == 2);
      opcode_i = (inject && c == 2) ? 8'h9C : op;
    end
    start_i = 1'b0;
  endtask

  task automatic check_regs(input string tag);
    chk(sp_o == m_sp, {tag, " sp"}, sp_o, m_sp);
    chk(pc_o == m_pc, {tag, " pc"}, pc_o, m_pc);
    chk(ccr_o == m_ccr, {tag, " ccr"}, ccr_o, m_ccr);
    chk(acc_o == m_acc, {tag, " acc"}, acc_o, m_acc);
    chk(idx_o == {HX0[15:8], m_ixl}, {tag, " idx R7"}, idx_o, {HX0[15:8], m_ixl});
  endtask

  task automatic t_reset();
    m_sp = SP0; m_pc = '0; m_ccr = CCR0; m_acc = '0; m_ixl = HX0[7:0];
    chk(!busy_o && !done_o && !mem_rd_o, "reset idle", {busy_o, done_o, mem_rd_o}, 0);
    check_regs("reset");
  endtask

  task automatic t_rsp(input string tag);
    int at, cnt;
    run_op(8'h9C, 1'b0, at, cnt);
    m_sp[7:0] = 8'hFF;
    chk(at == 1 && cnt == 1, {tag, " R1 done cycle"}, at, 1);
    chk(rd_n == 0, {tag, " R1 no read"}, rd_n, 0);
    check_regs({tag, " R1"});
  endtask

  task automatic t_rts(input logic [7:0] s, input bit inject, input string tag);
    int at, cnt;
    logic [15:0] base;
    salt = s; base = m_sp;
    run_op(8'h81, inject, at, cnt);
    chk(at == 5 && cnt == 1, {tag, " R5 rts done"}, {at[15:0], cnt[15:0]}, {16'd5, 16'd1});
    chk(rd_n == 2, {tag, " R2 rts reads"}, rd_n, 2);
    for (int k = 0; k < 2; k++)
      chk(rd_addr[k] == 16'(base + 16'(k + 1)), {tag, " R2 R9 rts addr"}, rd_addr[k], 16'(base + 16'(k + 1)));
    m_pc = {mem_f(16'(base + 16'd1), s), mem_f(16'(base + 16'd2), s)};
    m_sp = 16'(base + 16'd2);
    check_regs({tag, " R3 R6 R8"});
  endtask

  task automatic t_rti(input logic [7:0] s, input bit inject, input string tag);
    int at, cnt;
    logic [15:0] base;
    salt = s; base = m_sp;
    run_op(8'h80, inject, at, cnt);
    chk(at == 9 && cnt == 1, {tag, " R5 rti done"}, {at[15:0], cnt[15:0]}, {16'd9, 16'd1});
    chk(rd_n == 5, {tag, " R2 rti reads"}, rd_n, 5);
    for (int k = 0; k < 5; k++)
      chk(rd_addr[k] == 16'(base + 16'(k + 1)), {tag, " R2 R9 rti addr"}, rd_addr[k], 16'(base + 16'(k + 1)));
    m_ccr = mem_f(16'(base + 16'd1), s);
    m_acc = mem_f(16'(base + 16'd2), s);
    m_ixl = mem_f(16'(base + 16'd3), s);
    m_pc  = {mem_f(16'(base + 16'd4), s), mem_f(16'(base + 16'd5), s)};
    m_sp  = 16'(base + 16'd5);
    check_regs({tag, " R4 R8"});
  endtask

  task automatic t_bad_op();
    int at, cnt;
    run_op(8'h42, 1'b0, at, cnt);
    chk(cnt == 0, "R10 no done", cnt, 0);
    chk(rd_n == 0 && !busy_o, "R10 no read or busy", rd_n, 0);
    check_regs("R10 state");
  endtask

  initial begin
    #4_000_000;
    checks++; fails++;
    $display("FAIL watchdog R5 actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_rts(8'h11, 1'b0, "rts_top");   // FFFD, FFFE
    t_rsp("rsp_high");               // FFFF, high byte kept
    t_rti(8'h5A, 1'b0, "rti_wrap");  // 0000..0004 after wrap
    t_bad_op();
    t_rti(8'hC3, 1'b1, "rti_inject");
    t_rts(8'h7E, 1'b1, "rts_inject");
    t_rsp("rsp_low");                // 00FF
    summary();
    $finish;
  end
endmodule